// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the program counter of a word-addressed instruction stream and decides its next value for each decoded instruction. A decoder hands it one operation at a time: a plain step, a jump, a call, a return or a stop. Jumps may be absolute or relative, and either unconditional or gated on the zero flag, the carry flag or the inverse of either. Relative displacements are measured from the already-advanced PC, which is the address after the current instruction. Calls also emit a write of that advanced PC to the link register, and a return reloads the PC from the link register's value.

Every new PC value is checked against the code length. A value that is negative or not below the code length is refused: the PC stays where it was, and the unit raises a sticky range error and halts. A stop operation halts the unit without an error. Once halted, the unit deasserts `op_ready` and ignores all operations until reset. Operations enter on a valid/ready handshake. One operation is taken on each clock edge where `op_valid` and `op_ready` are both high. The unit never applies back-pressure except through halting, so `op_ready` is simply the inverse of `halted`. All outputs are registered and reflect an accepted operation after the clock edge that accepts it.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset `pc` is 0, `halted`, `range_err` and `lr_we` are 0, and `op_ready` is 1.
- R2: An accepted step operation (`op_kind` 0, and any code 5 to 7) sets `pc` to `pc`+1.
- R3: A jump (`op_kind` 1) is gated by `cond_sel`: 0 always, 1 Z set, 2 Z clear, 3 C set, 4 C clear, 5 to 7 always. When the condition fails, `pc` becomes `pc`+1.
- R4: A taken jump with `op_rel`=0 loads `pc` with the full 16-bit `target`.
- R5: With `op_rel`=1 the new `pc` is `pc`+1 plus `target[7:0]` read as two's complement, so the offset spans -128 to +127. Bit pattern 0x80 means -128, and `target[15:8]` is ignored.
- R6: A call (`op_kind` 2) branches unconditionally, absolute or relative as for jumps, and ignores `cond_sel`. In the cycle after acceptance, `lr_we` is 1 for one cycle with `lr_wdata` equal to the old `pc`+1.
- R7: A return (`op_kind` 3) sets `pc` to `lr_value`.
- R8: If the new PC would be negative or at least `code_len`, `pc` keeps its value, `range_err` and `halted` become 1, and no link write occurs.
- R9: A stop (`op_kind` 4) sets `halted`, leaves `range_err` at 0 and keeps `pc`.
- R10: While halted, `op_ready` is 0 and `pc`, `halted` and `range_err` do not change until reset.
- R11: Without `op_valid`, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation (not halted) |
| op_kind | input | 3 | 0 step, 1 jump, 2 call, 3 return, 4 stop |
| op_rel | input | 1 | 1: relative target, 0: absolute |
| cond_sel | input | 3 | Jump condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| target | input | 16 | Absolute address or displacement in the low byte |
| lr_value | input | 16 | Current link register contents, used by return |
| code_len | input | 16 | Number of words in the program |
| pc | output | 16 | Program counter |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | 16 | Return address to write |
| halted | output | 1 | Execution stopped |
| range_err | output | 1 | Stopped because of an illegal PC |

## Verification
The bound checker watches, on every cycle, the invariants that hold regardless of the program. A halt is sticky and freezes the PC. An error always comes with a halt. A link write can only follow an accepted call. A stop never produces an error. An idle cycle leaves the PC alone. The actual arithmetic can only be shown by the bench's scenarios: the condition decode, the signed low-byte displacement with ignored upper bits, the exact boundary at `code_len`-1 against `code_len`, a negative result, and a refused call that must not write the link register.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;
  typedef enum logic [2:0] {
    K_STEP = 3'd0,
    K_JUMP = 3'd1,
    K_CALL = 3'd2,
    K_RET  = 3'd3,
    K_STOP = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    C_ALWAYS = 3'd0,
    C_ZSET   = 3'd1,
    C_ZCLR   = 3'd2,
    C_CSET   = 3'd3,
    C_CCLR   = 3'd4
  } cond_e;
endpackage

// File: rtl/pcbu_cond.sv
module pcbu_cond
  import pcbu_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       z,
  input  logic       c,
  output logic       pass
);
  always_comb begin
    case (cond_e'(sel))
      C_ZSET:  pass = z;
      C_ZCLR:  pass = !z;
      C_CSET:  pass = c;
      C_CCLR:  pass = !c;
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/pcbu_target.sv
module pcbu_target
  import pcbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [2:0]        kind,
  input  logic              rel,
  input  logic              pass,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] lr_in,
  input  logic [ADDR_W-1:0] code_len,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              bad
);
  localparam int CW = ADDR_W + 2;

  logic [CW-1:0] seq, off, abs_t, branch_t, dst;
  logic          neg, over;

  always_comb begin
    seq      = {2'b00, pc} + CW'(1);
    off      = {{(CW-OFF_W){target[OFF_W-1]}}, target[OFF_W-1:0]};
    abs_t    = {2'b00, target};
    branch_t = rel ? (seq + off) : abs_t;
    case (op_kind_e'(kind))
      K_JUMP:  dst = pass ? branch_t : seq;
      K_CALL:  dst = branch_t;
      K_RET:   dst = {2'b00, lr_in};
      default: dst = seq;
    endcase
    neg      = dst[CW-1];
    over     = !neg && (dst[CW-2:0] >= {1'b0, code_len});
    bad      = neg || over;
    next_pc  = dst[ADDR_W-1:0];
    ret_addr = seq[ADDR_W-1:0];
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_kind,
  input  logic              op_rel,
  input  logic [2:0]        cond_sel,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] lr_value,
  input  logic [ADDR_W-1:0] code_len,
  output logic [ADDR_W-1:0] pc,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_wdata,
  output logic              halted,
  output logic              range_err
);
  logic [ADDR_W-1:0] pc_q, cand, ret_a, lrd_q;
  logic              halt_q, err_q, lrwe_q, cond_ok, cand_bad, take;

  pcbu_cond u_cond (
    .sel (cond_sel),
    .z   (flag_z),
    .c   (flag_c),
    .pass(cond_ok)
  );

  pcbu_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc      (pc_q),
    .kind    (op_kind),
    .rel     (op_rel),
    .pass    (cond_ok),
    .target  (target),
    .lr_in   (lr_value),
    .code_len(code_len),
    .next_pc (cand),
    .ret_addr(ret_a),
    .bad     (cand_bad)
  );

  assign take = op_valid && !halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      err_q  <= 1'b0;
      lrwe_q <= 1'b0;
      lrd_q  <= '0;
    end else begin
      lrwe_q <= 1'b0;
      if (take) begin
        if (op_kind_e'(op_kind) == K_STOP) begin
          halt_q <= 1'b1;
        end else if (cand_bad) begin
          halt_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          pc_q <= cand;
          if (op_kind_e'(op_kind) == K_CALL) begin
            lrwe_q <= 1'b1;
            lrd_q  <= ret_a;
          end
        end
      end
    end
  end

  assign op_ready  = !halt_q;
  assign pc        = pc_q;
  assign lr_we     = lrwe_q;
  assign lr_wdata  = lrd_q;
  assign halted    = halt_q;
  assign range_err = err_q;
endmodule

// File: rtl/pcbu_chk.sv
module pcbu_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_kind,
  input logic [ADDR_W-1:0] pc,
  input logic              lr_we,
  input logic              halted,
  input logic              range_err
);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc) && $stable(range_err));

  // R8
  err_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> halted);

  // R6
  link_after_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> $past(op_valid && op_ready && op_kind == 3'd2));

  // R9
  stop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind == 3'd4) |=> (halted && !range_err));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pc));
endmodule

bind pc_branch_unit pcbu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_kind  (op_kind),
  .pc       (pc),
  .lr_we    (lr_we),
  .halted   (halted),
  .range_err(range_err)
);

// File: tb/tb_pc_branch_unit.sv
module tb_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = '0;
  logic        op_rel = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [15:0] target = '0;
  logic [15:0] lr_value = '0;
  logic [15:0] code_len = 16'd1000;
  logic [15:0] pc;
  logic        lr_we;
  logic [15:0] lr_wdata;
  logic        halted;
  logic        range_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pc_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_rel(op_rel), .cond_sel(cond_sel),
    .flag_z(flag_z), .flag_c(flag_c), .target(target),
    .lr_value(lr_value), .code_len(code_len), .pc(pc), .lr_we(lr_we),
    .lr_wdata(lr_wdata), .halted(halted), .range_err(range_err)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offer one operation for one edge; results are sampled on the next negedge.
  task automatic issue(int kind, bit rel, int cond, bit z, bit c, int tgt);
    op_kind  = 3'(kind);
    op_rel   = rel;
    cond_sel = 3'(cond);
    flag_z   = z;
    flag_c   = c;
    target   = 16'(tgt);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc, 0);
    chk("R1 halted", halted, 0);
    chk("R1 range_err", range_err, 0);
    chk("R1 lr_we", lr_we, 0);
    chk("R1 op_ready", op_ready, 1);
  endtask

  task automatic t_step();
    issue(0, 0, 0, 0, 0, 777);
    chk("R2 step", pc, 1);
    issue(6, 0, 0, 0, 0, 0);
    chk("R2 unused kind steps", pc, 2);
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle hold", pc, 2);
  endtask

  task automatic t_abs_rel();
    issue(1, 0, 0, 0, 0, 500);
    chk("R4 absolute", pc, 500);
    issue(1, 1, 0, 0, 0, 127);
    chk("R5 +127", pc, 628);
    issue(1, 1, 0, 0, 0, 16'h0080);
    chk("R5 0x80 is -128", pc, 501);
    issue(1, 1, 0, 0, 0, 16'hAB80);
    chk("R5 upper byte ignored", pc, 374);
    issue(1, 1, 0, 0, 0, 16'h00FF);
    chk("R5 -1 lands on self", pc, 374);
    issue(1, 1, 0, 0, 0, 0);
    chk("R5 +0", pc, 375);
  endtask

  task automatic t_cond();
    for (int s = 1; s <= 4; s++) begin
      bit z_take = (s == 1);
      bit c_take = (s == 3);
      int base;
      // taken case
      issue(1, 0, s, (s == 1) ? 1'b1 : 1'b0, (s == 3) ? 1'b1 : 1'b0, 10 * s);
      chk("R3 taken", pc, 10 * s);
      base = 10 * s;
      // failed case: invert the tested flag
      issue(1, 0, s, (s == 1) ? 1'b0 : 1'b1, (s == 3) ? 1'b0 : 1'b1, 900);
      chk("R3 not taken", pc, base + 1);
      if (z_take || c_take) begin end
    end
    issue(1, 0, 7, 0, 0, 300);
    chk("R3 selector 7 always", pc, 300);
  endtask

  task automatic t_call_ret();
    issue(2, 0, 1, 0, 0, 200);
    chk("R6 call abs pc", pc, 200);
    chk("R6 lr_we", lr_we, 1);
    chk("R6 lr_wdata", lr_wdata, 301);
    @(negedge clk);
    chk("R6 lr_we one cycle", lr_we, 0);
    issue(2, 1, 3, 0, 0, 5);
    chk("R6 call rel pc", pc, 206);
    chk("R6 call rel lr", lr_wdata, 201);
    lr_value = 16'd201;
    issue(3, 0, 0, 0, 0, 0);
    chk("R7 return", pc, 201);
    chk("R6 no link on return", lr_we, 0);
  endtask

  task automatic t_range_top();
    issue(1, 0, 0, 0, 0, 999);
    chk("R8 last word allowed", pc, 999);
    chk("R8 no error at end-1", range_err, 0);
    issue(0, 0, 0, 0, 0, 0);
    chk("R8 step past end held", pc, 999);
    chk("R8 error raised", range_err, 1);
    chk("R8 halted", halted, 1);
    issue(1, 0, 0, 0, 0, 5);
    chk("R10 ignored while halted", pc, 999);
    chk("R10 op_ready low", op_ready, 0);
  endtask

  task automatic t_range_neg();
    do_reset();
    issue(1, 1, 0, 0, 0, 16'h00FF);
    chk("R5 back to zero", pc, 0);
    issue(1, 1, 0, 0, 0, 16'h00FE);
    chk("R8 negative held", pc, 0);
    chk("R8 negative error", range_err, 1);
  endtask

  task automatic t_bad_call();
    do_reset();
    issue(2, 0, 0, 0, 0, 1000);
    chk("R8 bad call no link", lr_we, 0);
    chk("R8 bad call error", range_err, 1);
    chk("R8 bad call pc", pc, 0);
  endtask

  task automatic t_stop();
    do_reset();
    issue(0, 0, 0, 0, 0, 0);
    issue(4, 0, 0, 0, 0, 50);
    chk("R9 stop halts", halted, 1);
    chk("R9 stop no error", range_err, 0);
    chk("R9 stop pc kept", pc, 1);
    issue(1, 0, 0, 0, 0, 50);
    chk("R10 stop then ignored", pc, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_step();
        t_abs_rel();
        t_cond();
        t_call_ret();
        t_range_top();
        t_range_neg();
        t_bad_call();
        t_stop();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule